// File: doc/BRIEF.md
# Frame-Checked Serial Register Write Port

This block is the serial-slave front end of a configuration register file. A host drives chip select (active low), a serial clock and a data line. Each transaction is a 16-bit word sent most significant bit first. The top four bits pick one of sixteen registers and the remaining twelve are the payload. The word is only accepted when the chip-select window holds exactly sixteen rising serial-clock edges. A window with any other non-zero edge count is thrown away and raises a sticky framing-fault flag. A window with no edges at all leaves no trace.

All serial pins are oversampled in the system clock domain. An accepted word leaves the block on a valid/ready stream (`wr_valid`, `wr_ready`, `wr_addr`, `wr_data`). The stream holds one word at most. While a word waits unaccepted, its address and data stay frozen. A new well-formed frame that ends while the slot is still occupied is refused and treated as a framing fault. Register address 1 is also decoded locally into a six-bit channel-enable output.

A small diagnostic fault register latches external fault inputs. An accepted write clears it. While chip select is low, it is shifted back on the serial data output, followed by eight zero bits. That output floats whenever chip select is high.

Top module: `spi_wr_port`

## Requirements
- R1: After reset, `wr_valid` is 0, `gate_en` is 0, `fault_reg` is 0 and `frame_fault` is 0.
- R2: A window with exactly 16 rising `spi_sck` edges produces one stream word when `spi_cs_n` rises: `wr_addr` is the first four bits received and `wr_data` the next twelve, both MSB first.
- R3: A window with more than 16 rising edges produces no stream word and sets `frame_fault` (bit 7 of `fault_reg`).
- R4: A window with 1 to 15 rising edges produces no stream word and sets `frame_fault`.
- R5: A window with zero rising edges produces no stream word and leaves `fault_reg` unchanged. `spi_sck` edges while `spi_cs_n` is high have no effect.
- R6: An accepted word clears `fault_reg`, including `frame_fault`. Bits 6:0 of `fault_reg` latch any `fault_in` bit that is high, and stay set until cleared this way.
- R7: A cancelled window (R3, R4) does not clear bits 6:0 of `fault_reg`.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold. A well-formed window that ends while the slot is occupied is refused and sets `frame_fault`, without clearing the other bits. The slot frees on the cycle in which `wr_valid` and `wr_ready` are both 1.
- R9: An accepted word with address 1 loads `gate_en` from data bits 5:0, where bit n enables channel n. Words with other addresses leave `gate_en` unchanged.
- R10: While `spi_cs_n` is low, `spi_miso` presents `{fault_reg, 8'h00}` as captured when the window opened. The MSB comes first, and the next bit follows each falling `spi_sck` edge. `spi_miso` is high impedance while `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial diagnostic data out, high impedance when deselected |
| fault_in | input | 7 | Fault event inputs, latched into fault_reg[6:0] |
| wr_valid | output | 1 | Stream word available |
| wr_ready | input | 1 | Stream consumer accepts word |
| wr_addr | output | 4 | Register address of the stream word |
| wr_data | output | 12 | Payload of the stream word |
| gate_en | output | 6 | Channel enables from register 1 |
| fault_reg | output | 8 | Diagnostic fault register, bit 7 is the framing fault |
| frame_fault | output | 1 | Copy of fault_reg[7] |

## Verification
The hardest case to reach is a well-formed frame that arrives while the single stream slot is still held by an unaccepted word. The stimulus gets there by holding `wr_ready` low across two complete frames. It then checks three things: the first word stays frozen, the second is refused with a framing fault, and only the first word comes out once ready returns. The overlong case is also pushed well past the counter's saturation point, using a 40-edge window. A cancelled frame is sent while an external fault is latched, and the next frame's shifted-out bits show the combined fault byte.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 12;
  localparam int WORD_W    = ADDR_W + DATA_W;
  localparam int FAULT_W   = 7;
  localparam int GATE_W    = 6;
  localparam int GATE_ADDR = 1;
  localparam int CNT_W     = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_word_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_wr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n_s,
  input  logic     sck_s,
  input  logic     mosi_s,
  output logic     commit,
  output logic     abort,
  output wr_word_t word,
  output logic     win_open,
  output logic     sck_fall
);
  logic              cs_d, sck_d;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic              cs_rise, sck_rise;

  assign win_open = cs_d & ~cs_n_s;
  assign cs_rise  = ~cs_d & cs_n_s;
  assign sck_rise = ~sck_d & sck_s & ~cs_n_s;
  assign sck_fall = sck_d & ~sck_s & ~cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      commit <= 1'b0;
      abort  <= 1'b0;
    end else begin
      cs_d   <= cs_n_s;
      sck_d  <= sck_s;
      commit <= cs_rise && (cnt == CNT_W'(WORD_W));
      abort  <= cs_rise && (cnt != '0) && (cnt != CNT_W'(WORD_W));
      if (win_open) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[WORD_W-2:0], mosi_s};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  assign word = wr_word_t'(shreg);

  // R3
  cnt_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_SAT) && sck_rise && !win_open |=> cnt == CNT_SAT);
  // R4
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && abort));
endmodule

// File: rtl/spi_diag_tx.sv
module spi_diag_tx
  import spi_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] load_word,
  output logic              miso_bit,
  output logic              miso_oe
);
  logic [WORD_W-1:0] txreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txreg <= '0;
    end else if (load) begin
      txreg <= load_word;
    end else if (shift) begin
      txreg <= {txreg[WORD_W-2:0], 1'b0};
    end
  end

  assign miso_bit = txreg[WORD_W-1];
  assign miso_oe  = ~cs_n_s;

  // R10
  miso_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !shift |=> $stable(miso_bit));
endmodule

// File: rtl/spi_wr_port.sv
module spi_wr_port
  import spi_wr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_cs_n,
  input  logic               spi_sck,
  input  logic               spi_mosi,
  output logic               spi_miso,
  input  logic [FAULT_W-1:0] fault_in,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic [GATE_W-1:0]  gate_en,
  output logic [FAULT_W:0]   fault_reg,
  output logic               frame_fault
);
  localparam int FF_BIT = FAULT_W;

  logic [2:0]   pins_s;
  logic         cs_n_s, sck_s, mosi_s;
  logic         commit, abort, win_open, sck_fall;
  wr_word_t     word, slot;
  logic         slot_free, accept, refuse;
  logic         miso_bit, miso_oe;

  spi_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_mosi}), .q(pins_s));
  assign {cs_n_s, sck_s, mosi_s} = pins_s;

  spi_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s), .mosi_s(mosi_s),
    .commit(commit), .abort(abort), .word(word),
    .win_open(win_open), .sck_fall(sck_fall));

  spi_diag_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s),
    .load(win_open), .shift(sck_fall),
    .load_word({fault_reg, {(WORD_W-FAULT_W-1){1'b0}}}),
    .miso_bit(miso_bit), .miso_oe(miso_oe));

  assign spi_miso  = miso_oe ? miso_bit : 1'bz;
  assign slot_free = !wr_valid || wr_ready;
  assign accept    = commit && slot_free;
  assign refuse    = commit && !slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid  <= 1'b0;
      slot      <= '0;
      gate_en   <= '0;
      fault_reg <= '0;
    end else begin
      if (accept) begin
        wr_valid <= 1'b1;
        slot     <= word;
        if (word.addr == ADDR_W'(GATE_ADDR)) gate_en <= word.data[GATE_W-1:0];
      end else if (wr_valid && wr_ready) begin
        wr_valid <= 1'b0;
      end
      if (accept) begin
        fault_reg <= {1'b0, fault_in};
      end else begin
        fault_reg[FAULT_W-1:0] <= fault_reg[FAULT_W-1:0] | fault_in;
        if (abort || refuse) fault_reg[FF_BIT] <= 1'b1;
      end
    end
  end

  assign wr_addr     = slot.addr;
  assign wr_data     = slot.data;
  assign frame_fault = fault_reg[FF_BIT];

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R6
  commit_clears_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !frame_fault);
  // R3
  abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> frame_fault);
  // R7
  abort_keeps_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (fault_reg[FAULT_W-1:0] & $past(fault_reg[FAULT_W-1:0])) == $past(fault_reg[FAULT_W-1:0]));
endmodule

// File: tb/sim_spi_wr_port.sv
`timescale 1ns/1ps
module sim_spi_wr_port;
  logic        clk = 0, rst_n = 0;
  logic        cs_n = 1, sck = 0, mosi = 0;
  wire         miso;
  logic [6:0]  fault_in = 0;
  logic        wr_ready = 1;
  logic        wr_valid;
  logic [3:0]  wr_addr;
  logic [11:0] wr_data;
  logic [5:0]  gate_en;
  logic [7:0]  fault_reg;
  logic        frame_fault;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  logic [15:0] rx;
  logic        z_ok;

  spi_wr_port u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .fault_in(fault_in), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .gate_en(gate_en),
    .fault_reg(fault_reg), .frame_fault(frame_fault));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each stream handshake
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 actual=%0h expected=none", {wr_addr, wr_data});
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          n_bad++;
          $display("FAIL R2 actual=%0h expected=%0h", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  // driver: sends a window with nedges clock edges; push=1 queues the expected word
  task automatic send(input logic [15:0] w, input int nedges, input bit push);
    rx = 0;
    cs_n = 0;
    #80;
    for (int i = 0; i < nedges; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      #40 sck = 1;
      if (i < 16) rx[15-i] = miso;
      #40 sck = 0;
    end
    #80 cs_n = 1;
    if (push) exp_q.push_back(w);
    #200;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    @(negedge clk);
    // R1
    check("R1", {wr_valid, gate_en, fault_reg, frame_fault}, 0);
    #2;
    z_ok = (miso === 1'bz);
    check("R10 hiz", z_ok, 1);

    // R2 basic word, R9 gate register
    send(16'h102D, 16, 1);
    #20;
    check("R9", gate_en, 6'h2D);
    send(16'h5FFF, 16, 1);
    check("R9 other addr", gate_en, 6'h2D);
    send(16'hA3C5, 16, 1);

    // R5 zero edges and clocks while deselected
    send(16'h0, 0, 0);
    for (int i = 0; i < 8; i++) begin #40 sck = 1; #40 sck = 0; end
    #200;
    check("R5", {wr_valid, fault_reg}, 0);

    // R6 latch a fault
    fault_in = 7'h05; #50; fault_in = 0; #20;
    check("R6 latch", fault_reg, 8'h05);
    // R4 short frame, R7 faults kept
    send(16'h1FFF, 10, 0);
    check("R4", frame_fault, 1);
    check("R7", fault_reg, 8'h85);
    check("R9 short", gate_en, 6'h2D);
    // R10 shifted diagnostics, R6 clear on commit
    send(16'h7123, 16, 1);
    check("R10 data", rx, 16'h8500);
    check("R6 clear", fault_reg, 8'h00);
    // R3 overlong
    send(16'h1001, 40, 0);
    check("R3", frame_fault, 1);
    check("R3 gate", gate_en, 6'h2D);
    send(16'h1001, 17, 0);
    check("R3 17", gate_en, 6'h2D);

    // R8 back-pressure
    wr_ready = 0;
    send(16'h1015, 16, 1);
    check("R8 valid", wr_valid, 1);
    check("R8 ff clear", frame_fault, 0);
    #300;
    check("R8 hold", {wr_valid, wr_addr, wr_data}, {1'b1, 16'h1015});
    send(16'h2222, 16, 0);
    check("R8 refuse", frame_fault, 1);
    check("R8 held word", {wr_addr, wr_data}, 16'h1015);
    @(negedge clk); wr_ready = 1;
    #50;
    check("R8 drained", wr_valid, 0);
    check("R9 via stall", gate_en, 6'h15);
    check("R2 queue empty", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule